// File: doc/BRIEF.md
# Software-Generated Interrupt Source Tracker

This block keeps the pending state of the software-generated interrupts (SGIs) of a multi-core interrupt distributor. A CPU raises an SGI by naming the SGI number and a mask of target CPUs. The block records one pending bit for every combination of target, SGI number and source CPU. Two different cores that raise the same SGI to the same target are therefore held apart.

A target CPU acknowledges by presenting its own CPU number. One cycle later the block returns an interrupt ID and a source CPU number, and it clears only the bit that it reported. The SGI taken is the lowest-numbered one pending for that target. Among the cores that raised it, the lowest-numbered source is reported.

The block also accepts the generic set-pending and clear-pending register writes of the distributor. These writes update a pending word for the interrupt IDs above the SGI range. They never change any SGI.

Top module: `sgi_source_tracker`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, every SGI pending bit and every generic pending bit is cleared. After reset, `sgi_pend` and `periph_pend` read all zero.
- R2: A request (`req_valid`=1) sets the bit for (`req_src`, `req_sgi`) in every target CPU whose bit is 1 in `req_targets`. The change shows in `sgi_pend[t*NUM_SGI+s]` after that edge. Other targets are not touched.
- R3: An acknowledge (`ack_valid`=1, `ack_cpu`=t) picks the lowest-numbered SGI pending for target t. Among the sources of that SGI, it reports the lowest-numbered one. The response appears after the next edge: `ack_rdy`=1, `ack_data[9:0]` holds the SGI number as the interrupt ID and `ack_data[CPU_W+9:10]` holds the source CPU.
- R4: An acknowledge clears only the reported (target, SGI, source) bit. If other sources of that SGI remain, the SGI stays pending for the target, and later acknowledges report those sources in rising order. The pending state of other targets is unchanged.
- R5: An acknowledge from a target with nothing pending returns interrupt ID 1023 with source field 0, and it changes no state.
- R6: A request and an acknowledge in the same cycle for the same target and SGI are resolved as follows. The acknowledge is served from the state before that edge. The requested bit is pending after the edge, even when it is the very bit the acknowledge cleared.
- R7: Set-pending and clear-pending writes (`pend_set_we`, `pend_clr_we`) never change any SGI pending bit. Bits 0 to NUM_SGI-1 of `periph_pend` always read 0.
- R8: For IDs NUM_SGI to NUM_IRQ-1, a set-pending write sets each `periph_pend` bit whose `pend_wdata` bit is 1. A clear-pending write clears each such bit. When both writes happen in the same cycle, the set wins.
- R9: When `ack_valid` is 0 in a cycle, `ack_rdy` is 0 after the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | SGI request strobe |
| req_src | input | CPU_W | Requesting (source) CPU |
| req_sgi | input | SGI_W | SGI number requested |
| req_targets | input | NUM_CPU | One bit per target CPU |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_cpu | input | CPU_W | Acknowledging target CPU |
| ack_rdy | output | 1 | Acknowledge response valid |
| ack_data | output | CPU_W+10 | {source CPU, 10-bit interrupt ID} |
| pend_set_we | input | 1 | Set-pending write strobe |
| pend_clr_we | input | 1 | Clear-pending write strobe |
| pend_wdata | input | NUM_IRQ | One bit per interrupt ID |
| sgi_pend | output | NUM_CPU*NUM_SGI | Per target, per SGI: any source pending |
| periph_pend | output | NUM_IRQ | Generic pending word |

## Verification
The bench builds the block with four CPUs, all sixteen SGIs and a 32-bit pending word. This makes the whole state of 256 pending bits small enough to mirror in a bench model. With that size, every source and SGI pair can be raised and then drained target by target until the spurious ID returns. The bench also covers same-SGI multi-source ordering, simultaneous request and acknowledge on a single bit, and register writes with all-ones data. A long mixed phase with pseudo-random requests, acknowledges and writes then compares every response and pending bit against the model.

// File: rtl/sgi_trk_pkg.sv
`timescale 1ns/1ps
// Shared constants of the SGI source tracker.
// Assumes a 10-bit interrupt ID space with 1023 reserved as the spurious ID.
package sgi_trk_pkg;
    localparam int SGI_COUNT   = 16;
    localparam int IRQ_ID_W    = 10;
    localparam int SPURIOUS_ID = 1023;
endpackage

// File: rtl/sgi_lowest_pick.sv
`timescale 1ns/1ps
// Fixed lowest-index picker: returns the index of the lowest set bit.
// Assumes IDX_W is wide enough to hold WIDTH-1.
module sgi_lowest_pick #(
    parameter int WIDTH = 8,
    parameter int IDX_W = 3
) (
    input  logic [WIDTH-1:0] req,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    // Scan from the top down so the lowest set bit is the last one written.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = WIDTH - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/sgi_target_slice.sv
`timescale 1ns/1ps
// Pending matrix of one target CPU: one bit per (SGI, source CPU).
// Bit index is sgi*NUM_CPU + src. Set beats clear on the same bit.
// Assumes at most one set and one clear per cycle.
module sgi_target_slice #(
    parameter int NUM_CPU = 8,
    parameter int NUM_SGI = 16,
    parameter int CPU_W   = 3,
    parameter int SGI_W   = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       set_en,
    input  logic [SGI_W-1:0]           set_sgi,
    input  logic [CPU_W-1:0]           set_src,
    input  logic                       clr_en,
    input  logic [SGI_W-1:0]           clr_sgi,
    input  logic [CPU_W-1:0]           clr_src,
    output logic [NUM_SGI*NUM_CPU-1:0] pend_q,
    output logic [NUM_SGI-1:0]         any_q
);
    localparam int BITS = NUM_SGI * NUM_CPU;

    logic [BITS-1:0] set_vec;
    logic [BITS-1:0] clr_vec;

    // Decode the set and clear coordinates into one-hot bit vectors.
    for (genvar s = 0; s < NUM_SGI; s++) begin : g_sgi
        for (genvar c = 0; c < NUM_CPU; c++) begin : g_src
            assign set_vec[s*NUM_CPU + c] = set_en && (set_sgi == SGI_W'(s)) && (set_src == CPU_W'(c));
            assign clr_vec[s*NUM_CPU + c] = clr_en && (clr_sgi == SGI_W'(s)) && (clr_src == CPU_W'(c));
        end
        assign any_q[s] = |pend_q[s*NUM_CPU +: NUM_CPU];
    end

    // Update the matrix: clear the acknowledged bit, then apply the new request.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~clr_vec) | set_vec;
    end

    // R2: a requested bit is pending after the edge.
    a_r2_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec != '0) |=> ((pend_q & $past(set_vec)) == $past(set_vec)));

    // R4: a lone acknowledge removes exactly one bit.
    a_r4_single_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && !set_en) |=> ($countones(pend_q) == $countones($past(pend_q)) - 1));
endmodule

// File: rtl/sgi_ack_unit.sv
`timescale 1ns/1ps
// Acknowledge path: selects the target's matrix, picks the lowest SGI and
// its lowest source, drives the clear, and registers the response.
// Assumes the pend/any buses are packed target-major.
module sgi_ack_unit #(
    parameter int NUM_CPU = 8,
    parameter int NUM_SGI = 16,
    parameter int CPU_W   = 3,
    parameter int SGI_W   = 4
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                ack_valid,
    input  logic [CPU_W-1:0]                    ack_cpu,
    input  logic [NUM_CPU*NUM_SGI*NUM_CPU-1:0]  pend_all,
    input  logic [NUM_CPU*NUM_SGI-1:0]          any_all,
    output logic                                clr_en,
    output logic [SGI_W-1:0]                    clr_sgi,
    output logic [CPU_W-1:0]                    clr_src,
    output logic                                rsp_valid,
    output logic [sgi_trk_pkg::IRQ_ID_W-1:0]    rsp_id,
    output logic [CPU_W-1:0]                    rsp_src
);
    import sgi_trk_pkg::*;

    localparam int ROW = NUM_SGI * NUM_CPU;

    logic [ROW-1:0]     tgt_pend;
    logic [NUM_SGI-1:0] tgt_any;
    logic [NUM_CPU-1:0] src_row;
    logic               sgi_found;
    logic               src_found;
    logic [SGI_W-1:0]   sgi_idx;
    logic [CPU_W-1:0]   src_idx;

    // Route the acknowledging target's state to the pickers.
    always_comb begin
        tgt_pend = '0;
        tgt_any  = '0;
        for (int t = 0; t < NUM_CPU; t++) begin
            if (ack_cpu == CPU_W'(t)) begin
                tgt_pend = pend_all[t*ROW +: ROW];
                tgt_any  = any_all[t*NUM_SGI +: NUM_SGI];
            end
        end
    end

    sgi_lowest_pick #(.WIDTH(NUM_SGI), .IDX_W(SGI_W)) u_pick_sgi (
        .req(tgt_any), .found(sgi_found), .idx(sgi_idx));

    // Extract the source row of the chosen SGI.
    always_comb begin
        src_row = '0;
        for (int s = 0; s < NUM_SGI; s++) begin
            if (sgi_idx == SGI_W'(s)) src_row = tgt_pend[s*NUM_CPU +: NUM_CPU];
        end
    end

    sgi_lowest_pick #(.WIDTH(NUM_CPU), .IDX_W(CPU_W)) u_pick_src (
        .req(src_row), .found(src_found), .idx(src_idx));

    assign clr_en  = ack_valid && sgi_found && src_found;
    assign clr_sgi = sgi_idx;
    assign clr_src = src_idx;

    // Register the acknowledge result; an empty target yields the spurious ID.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_id    <= IRQ_ID_W'(SPURIOUS_ID);
            rsp_src   <= '0;
        end else begin
            rsp_valid <= ack_valid;
            if (ack_valid) begin
                rsp_id  <= clr_en ? IRQ_ID_W'(sgi_idx) : IRQ_ID_W'(SPURIOUS_ID);
                rsp_src <= clr_en ? src_idx : '0;
            end
        end
    end

    // R3: a non-spurious response names an SGI.
    a_r3_id_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_id != IRQ_ID_W'(SPURIOUS_ID)) |-> (int'(rsp_id) < NUM_SGI));

    // R5: an acknowledge on an empty target answers spurious with source 0.
    a_r5_empty_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && !sgi_found) |=> (rsp_id == IRQ_ID_W'(SPURIOUS_ID) && rsp_src == '0));

    // R9: no response without an acknowledge.
    a_r9_no_spurious_rdy: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_valid |=> !rsp_valid);
endmodule

// File: rtl/sgi_periph_pend.sv
`timescale 1ns/1ps
// Generic pending word written by the set-pending / clear-pending ports.
// SGI bit positions are masked off so those writes never reach SGI state.
module sgi_periph_pend #(
    parameter int NUM_IRQ = 32,
    parameter int NUM_SGI = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               set_we,
    input  logic               clr_we,
    input  logic [NUM_IRQ-1:0] wdata,
    output logic [NUM_IRQ-1:0] pend_q
);
    localparam logic [NUM_IRQ-1:0] WMASK = {{(NUM_IRQ-NUM_SGI){1'b1}}, {NUM_SGI{1'b0}}};

    logic [NUM_IRQ-1:0] set_m;
    logic [NUM_IRQ-1:0] clr_m;

    assign set_m = set_we ? (wdata & WMASK) : '0;
    assign clr_m = clr_we ? (wdata & WMASK) : '0;

    // Apply clear then set, so a simultaneous set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~clr_m) | set_m;
    end

    // R8: every writable bit named by a set-pending write is pending afterwards.
    a_r8_set_visible: assert property (@(posedge clk) disable iff (!rst_n)
        set_we |=> ((pend_q & ($past(wdata) & WMASK)) == ($past(wdata) & WMASK)));

    // R7: SGI positions of the generic word stay zero.
    a_r7_sgi_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
        set_we |=> (pend_q[NUM_SGI-1:0] == '0));
endmodule

// File: rtl/sgi_source_tracker.sv
`timescale 1ns/1ps
// SGI source tracker: per-target, per-SGI, per-source pending matrix with a
// request port, an acknowledge port reporting the lowest source, and
// generic set/clear pending writes that leave SGIs alone.
// Assumes one request and one acknowledge per cycle.
module sgi_source_tracker #(
    parameter int NUM_CPU = 8,
    parameter int NUM_SGI = sgi_trk_pkg::SGI_COUNT,
    parameter int NUM_IRQ = 32,
    localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
    localparam int SGI_W  = $clog2(NUM_SGI),
    localparam int DATA_W = CPU_W + sgi_trk_pkg::IRQ_ID_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    input  logic [CPU_W-1:0]           req_src,
    input  logic [SGI_W-1:0]           req_sgi,
    input  logic [NUM_CPU-1:0]         req_targets,
    input  logic                       ack_valid,
    input  logic [CPU_W-1:0]           ack_cpu,
    output logic                       ack_rdy,
    output logic [DATA_W-1:0]          ack_data,
    input  logic                       pend_set_we,
    input  logic                       pend_clr_we,
    input  logic [NUM_IRQ-1:0]         pend_wdata,
    output logic [NUM_CPU*NUM_SGI-1:0] sgi_pend,
    output logic [NUM_IRQ-1:0]         periph_pend
);
    import sgi_trk_pkg::*;

    localparam int ROW = NUM_SGI * NUM_CPU;

    logic [NUM_CPU*ROW-1:0] pend_all;
    logic                   clr_en;
    logic [SGI_W-1:0]       clr_sgi;
    logic [CPU_W-1:0]       clr_src;
    logic [IRQ_ID_W-1:0]    rsp_id;
    logic [CPU_W-1:0]       rsp_src;

    // One pending slice per target CPU.
    for (genvar t = 0; t < NUM_CPU; t++) begin : g_tgt
        sgi_target_slice #(
            .NUM_CPU(NUM_CPU), .NUM_SGI(NUM_SGI), .CPU_W(CPU_W), .SGI_W(SGI_W)
        ) u_slice (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_en  (req_valid && req_targets[t]),
            .set_sgi (req_sgi),
            .set_src (req_src),
            .clr_en  (clr_en && (ack_cpu == CPU_W'(t))),
            .clr_sgi (clr_sgi),
            .clr_src (clr_src),
            .pend_q  (pend_all[t*ROW +: ROW]),
            .any_q   (sgi_pend[t*NUM_SGI +: NUM_SGI])
        );
    end

    sgi_ack_unit #(
        .NUM_CPU(NUM_CPU), .NUM_SGI(NUM_SGI), .CPU_W(CPU_W), .SGI_W(SGI_W)
    ) u_ack (
        .clk       (clk),
        .rst_n     (rst_n),
        .ack_valid (ack_valid),
        .ack_cpu   (ack_cpu),
        .pend_all  (pend_all),
        .any_all   (sgi_pend),
        .clr_en    (clr_en),
        .clr_sgi   (clr_sgi),
        .clr_src   (clr_src),
        .rsp_valid (ack_rdy),
        .rsp_id    (rsp_id),
        .rsp_src   (rsp_src)
    );

    assign ack_data = {rsp_src, rsp_id};

    sgi_periph_pend #(.NUM_IRQ(NUM_IRQ), .NUM_SGI(NUM_SGI)) u_periph (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_we (pend_set_we),
        .clr_we (pend_clr_we),
        .wdata  (pend_wdata),
        .pend_q (periph_pend)
    );

    // R7: register writes alone leave every SGI pending bit as it was.
    a_r7_wr_no_sgi: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_set_we || pend_clr_we) && !req_valid && !ack_valid) |=> $stable(pend_all));
endmodule

// File: tb/sgi_source_tracker_test.sv
`timescale 1ns/1ps
module sgi_source_tracker_test;
    localparam int NC = 4;
    localparam int NS = 16;
    localparam int NI = 32;
    localparam logic [NI-1:0] WM = {{(NI-NS){1'b1}}, {NS{1'b0}}};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [1:0]    req_src = '0;
    logic [3:0]    req_sgi = '0;
    logic [NC-1:0] req_targets = '0;
    logic          ack_valid = 1'b0;
    logic [1:0]    ack_cpu = '0;
    logic          ack_rdy;
    logic [11:0]   ack_data;
    logic          pend_set_we = 1'b0;
    logic          pend_clr_we = 1'b0;
    logic [NI-1:0] pend_wdata = '0;
    logic [NC*NS-1:0] sgi_pend;
    logic [NI-1:0] periph_pend;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;
    bit  mdl [NC][NS][NC];
    logic [NI-1:0] pm = '0;

    always #2.5 clk = ~clk;

    sgi_source_tracker #(.NUM_CPU(NC), .NUM_SGI(NS), .NUM_IRQ(NI)) uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_src(req_src), .req_sgi(req_sgi), .req_targets(req_targets),
        .ack_valid(ack_valid), .ack_cpu(ack_cpu), .ack_rdy(ack_rdy), .ack_data(ack_data),
        .pend_set_we(pend_set_we), .pend_clr_we(pend_clr_we), .pend_wdata(pend_wdata),
        .sgi_pend(sgi_pend), .periph_pend(periph_pend)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [NC*NS-1:0] mdl_view();
        logic [NC*NS-1:0] v = '0;
        for (int t = 0; t < NC; t++)
            for (int s = 0; s < NS; s++)
                for (int c = 0; c < NC; c++)
                    if (mdl[t][s][c]) v[t*NS + s] = 1'b1;
        return v;
    endfunction

    task automatic clear_model();
        for (int t = 0; t < NC; t++)
            for (int s = 0; s < NS; s++)
                for (int c = 0; c < NC; c++)
                    mdl[t][s][c] = 1'b0;
        pm = '0;
    endtask

    // One cycle: drive at the falling edge, update model, check after the rising edge.
    task automatic cyc(input bit rv, input int rs, input int rg, input logic [NC-1:0] rt,
                       input bit av, input int ac, input bit sw, input bit cw,
                       input logic [NI-1:0] wd, input string tag);
        bit ef = 1'b0;
        int esg = 0;
        int esr = 0;
        logic [11:0] exp_data;
        @(negedge clk);
        req_valid = rv; req_src = 2'(rs); req_sgi = 4'(rg); req_targets = rt;
        ack_valid = av; ack_cpu = 2'(ac);
        pend_set_we = sw; pend_clr_we = cw; pend_wdata = wd;
        for (int s = 0; s < NS; s++)
            for (int c = 0; c < NC; c++)
                if (!ef && mdl[ac][s][c]) begin ef = 1'b1; esg = s; esr = c; end
        exp_data = ef ? {2'(esr), 10'(esg)} : {2'b00, 10'd1023};
        if (av && ef) mdl[ac][esg][esr] = 1'b0;
        if (rv) for (int t = 0; t < NC; t++) if (rt[t]) mdl[t][rg][rs] = 1'b1;
        if (cw) pm = pm & ~(wd & WM);
        if (sw) pm = pm | (wd & WM);
        @(posedge clk);
        #1;
        if (av) begin
            check(ack_rdy === 1'b1, {tag, " R3 ack_rdy"}, 64'(ack_rdy), 64'd1);
            check(ack_data === exp_data, {tag, " R3/R4/R5 ack_data"}, 64'(ack_data), 64'(exp_data));
        end else begin
            check(ack_rdy === 1'b0, {tag, " R9 ack_rdy idle"}, 64'(ack_rdy), 64'd0);
        end
        check(sgi_pend === mdl_view(), {tag, " R2/R4/R7 sgi_pend"}, 64'(sgi_pend), 64'(mdl_view()));
        check(periph_pend === pm, {tag, " R8 periph_pend"}, 64'(periph_pend), 64'(pm));
        req_valid = 1'b0; ack_valid = 1'b0; pend_set_we = 1'b0; pend_clr_we = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        clear_model();
        #1;
        check(sgi_pend === '0, "R1 sgi_pend after reset", 64'(sgi_pend), 64'd0);
        check(periph_pend === '0, "R1 periph_pend after reset", 64'(periph_pend), 64'd0);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        clear_model();
        do_reset();

        // R5: every target empty after reset -> spurious.
        for (int t = 0; t < NC; t++) cyc(0, 0, 0, '0, 1, t, 0, 0, '0, "R5 empty ack");

        // R2/R3/R4: raise every source/SGI pair to varying target sets, then drain.
        for (int c = 0; c < NC; c++)
            for (int s = 0; s < NS; s++)
                cyc(1, c, s, 4'(((c + s) % 15) + 1), 0, 0, 0, 0, '0, "R2 sweep");
        for (int t = 0; t < NC; t++)
            for (int k = 0; k < NS * NC + 2; k++)
                cyc(0, 0, 0, '0, 1, t, 0, 0, '0, "R3 R4 drain");

        // R4: three sources on one SGI to target 0 are reported 1, 2, 3 in order.
        cyc(1, 3, 5, 4'b0001, 0, 0, 0, 0, '0, "R4 load");
        cyc(1, 1, 5, 4'b0001, 0, 0, 0, 0, '0, "R4 load");
        cyc(1, 2, 5, 4'b0101, 0, 0, 0, 0, '0, "R4 load");
        for (int k = 0; k < 4; k++) cyc(0, 0, 0, '0, 1, 0, 0, 0, '0, "R4 multi-source");
        cyc(0, 0, 0, '0, 1, 2, 0, 0, '0, "R4 other target kept");

        // R6: simultaneous request and acknowledge on the same SGI.
        cyc(1, 2, 7, 4'b0010, 0, 0, 0, 0, '0, "R6 load");
        cyc(1, 0, 7, 4'b0010, 1, 1, 0, 0, '0, "R6 ack+req other src");
        cyc(1, 0, 7, 4'b0010, 1, 1, 0, 0, '0, "R6 ack+req same bit");
        cyc(0, 0, 0, '0, 1, 1, 0, 0, '0, "R6 re-pended");
        cyc(0, 0, 0, '0, 1, 1, 0, 0, '0, "R6 empty");

        // R7/R8: register writes with SGI state present.
        cyc(1, 3, 0, 4'b1111, 0, 0, 0, 0, '0, "R7 load");
        cyc(1, 1, 15, 4'b1001, 0, 0, 0, 0, '0, "R7 load");
        cyc(0, 0, 0, '0, 0, 0, 1, 0, '1, "R7 set all ones");
        cyc(0, 0, 0, '0, 0, 0, 0, 1, 32'h0001_FFFF, "R7 clear low");
        cyc(0, 0, 0, '0, 0, 0, 1, 1, 32'hA5A5_5A5A, "R8 set wins");
        cyc(0, 0, 0, '0, 0, 0, 0, 1, '1, "R7 clear all ones");
        cyc(0, 0, 0, '0, 0, 0, 1, 0, 32'h8001_0000, "R8 edge bits");

        // Mixed pseudo-random phase.
        for (int k = 0; k < 3000; k++) begin
            logic [31:0] r = $urandom;
            cyc(r[0], int'(r[2:1]), int'(r[6:3]), r[10:7], r[11] | r[12], int'(r[14:13]),
                (r[17:15] == 3'd0), (r[20:18] == 3'd0), $urandom, "R2-mix");
        end

        // R1: reset in the middle of activity.
        cyc(1, 2, 9, 4'b1111, 0, 0, 1, 0, '1, "R1 preload");
        do_reset();
        cyc(0, 0, 0, '0, 1, 3, 0, 0, '0, "R1 R5 ack after reset");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule